// File: doc/BRIEF.md
# Big-integer row multiply-accumulate unit

This unit produces one row of a schoolbook long multiplication: a multi-limb operand A times a single limb B. An optional multi-limb addend C can be summed in. The limbs of A are taken from least to most significant, one per cycle, and one result limb leaves per cycle. A row over N limbs of A produces N+1 result limbs.

The high half of each double-width limb product is held in a register. It is added into the next limb position, together with the carry left by the previous limb sum. All operands are captured when a row starts. The caller may change its inputs while the row is running. With accumulation disabled, the C limbs are replaced by zero, so that C can be added later by a separate vector add. Summing several rows is left to the surrounding logic.

Top module: `bigRowMac`

## Requirements
- R1: A synchronous reset forces `resValid` and `resDone` low and clears the held high half, the carry and the limb counter. This holds even when the reset arrives in the middle of a row, and the next row after it is computed as if from a fresh start.
- R2: A `start` pulse while idle is accepted on that clock edge. From the following cycle, `resValid` is high for exactly LIMBS+1 consecutive cycles, and `resDone` is high only in the last of them. No valid cycle appears without an accepted start.
- R3: The first result limb (limb 0) equals C0 plus the low half of A0 times B, modulo 2^LW.
- R4: Each middle result limb i (0 < i < LIMBS) equals Ci, plus the low half of Ai times B, plus the high half of A(i-1) times B, plus the carry out of limb i-1's sum, modulo 2^LW. The carry out is the part of that sum at or above 2^LW.
- R5: The top result limb (index LIMBS) equals the high half of A(LIMBS-1) times B plus the final carry.
- R6: With `accEn` low at the start edge, C is treated as zero whatever the `cLimbs` input holds.
- R7: A `start` pulse while a row is in progress, including in the cycle that carries `resDone`, is ignored. The row in progress continues unchanged and no extra row follows.
- R8: When every limb of A, C and B is at its maximum value, the LIMBS+1 result limbs equal the exact value A*B+C with nothing lost.
- R9: `aLimbs`, `bLimb`, `cLimbs` and `accEn` are sampled only on the start edge. Changes to them during a row do not affect its result limbs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a row; accepted only while idle |
| accEn | input | 1 | Add the C operand when high; sampled at start |
| aLimbs | input | LIMBS*LW | Operand A; limb k in bits [k*LW +: LW] |
| bLimb | input | LW | Scalar limb B |
| cLimbs | input | LIMBS*LW | Addend C; limb k in bits [k*LW +: LW] |
| resLimb | output | LW | Current result limb, least significant first |
| resValid | output | 1 | resLimb holds a result limb |
| resDone | output | 1 | Final (top) limb of the row is on resLimb |

## Verification
The bench builds the unit with its defaults, LIMBS=4 and LW=64. This gives real 64x64 products and three middle limbs, so a carry can ripple through several positions before reaching the top limb. With these widths, the expected value can be formed as one 320-bit integer A*B+C and sliced into limbs. This makes the all-ones case and long carry chains directly comparable, and the expected value does not reuse the limb recurrence.

// File: rtl/bigRowPkg.sv
package bigRowPkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear high half and carry
    logic step;   // a result limb is emitted this cycle
    logic last;   // this is the top limb of the row
  } rowStrobes_t;
endpackage

// File: rtl/bigRowCtrl.sv
module bigRowCtrl
  import bigRowPkg::*;
#(
  parameter int LIMBS = 4,
  localparam int IW = $clog2(LIMBS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output rowStrobes_t   strb,
  output logic [IW-1:0] idx,
  output logic          busy
);
  localparam logic [IW-1:0] LASTIDX = IW'(LIMBS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (idx == LASTIDX) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    strb.load = !busy && start;
    strb.step = busy;
    strb.last = busy && (idx == LASTIDX);
  end
endmodule

// File: rtl/bigRowDatapath.sv
module bigRowDatapath
  import bigRowPkg::*;
#(
  parameter int LIMBS = 4,
  parameter int LW = 64,
  localparam int IW = $clog2(LIMBS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  rowStrobes_t         strb,
  input  logic [IW-1:0]       idx,
  input  logic                accEn,
  input  logic [LIMBS*LW-1:0] aIn,
  input  logic [LW-1:0]       bIn,
  input  logic [LIMBS*LW-1:0] cIn,
  output logic [LW-1:0]       limbOut
);
  logic [LIMBS-1:0][LW-1:0] aReg;
  logic [LIMBS-1:0][LW-1:0] cReg;
  logic [LW-1:0]   bReg;
  logic [LW-1:0]   hiHeld;
  logic [1:0]      carry;
  logic [LW-1:0]   aCur;
  logic [LW-1:0]   cCur;
  logic [2*LW-1:0] prod;
  logic [LW+1:0]   sum;

  // operand capture on the start edge only
  always_ff @(posedge clk) begin
    if (strb.load) begin
      bReg <= bIn;
      for (int k = 0; k < LIMBS; k++) begin
        aReg[k] <= aIn[k*LW +: LW];
        cReg[k] <= accEn ? cIn[k*LW +: LW] : '0;
      end
    end
  end

  // limb selection; the index LIMBS selects zeros for the top limb
  always_comb begin
    aCur = '0;
    cCur = '0;
    for (int k = 0; k < LIMBS; k++) begin
      if (idx == IW'(k)) begin
        aCur = aReg[k];
        cCur = cReg[k];
      end
    end
  end

  assign prod = {{LW{1'b0}}, aCur} * {{LW{1'b0}}, bReg};
  assign sum  = {2'b00, cCur} + {2'b00, prod[LW-1:0]} + {2'b00, hiHeld}
              + {{LW{1'b0}}, carry};
  assign limbOut = sum[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst || strb.load) begin
      hiHeld <= '0;
      carry  <= '0;
    end else if (strb.step) begin
      if (strb.last) begin
        hiHeld <= '0;
        carry  <= '0;
      end else begin
        hiHeld <= prod[2*LW-1:LW];
        carry  <= sum[LW+1:LW];
      end
    end
  end
endmodule

// File: rtl/bigRowMac.sv
module bigRowMac
  import bigRowPkg::*;
#(
  parameter int LIMBS = 4,
  parameter int LW = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                accEn,
  input  logic [LIMBS*LW-1:0] aLimbs,
  input  logic [LW-1:0]       bLimb,
  input  logic [LIMBS*LW-1:0] cLimbs,
  output logic [LW-1:0]       resLimb,
  output logic                resValid,
  output logic                resDone
);
  localparam int IW = $clog2(LIMBS + 1);

  rowStrobes_t   strb;
  logic [IW-1:0] idx;
  logic          busy;

  bigRowCtrl #(.LIMBS(LIMBS)) uCtrl (
    .clk(clk), .rst(rst), .start(start),
    .strb(strb), .idx(idx), .busy(busy)
  );

  bigRowDatapath #(.LIMBS(LIMBS), .LW(LW)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .idx(idx), .accEn(accEn),
    .aIn(aLimbs), .bIn(bLimb), .cIn(cLimbs), .limbOut(resLimb)
  );

  assign resValid = busy;
  assign resDone  = strb.last;
endmodule

// File: rtl/bigRowMacChk.sv
module bigRowMacChk #(
  parameter int LIMBS = 4,
  localparam int IW = $clog2(LIMBS + 1)
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic resValid,
  input logic resDone
);
  localparam logic [IW-1:0] LASTIDX = IW'(LIMBS);
  logic [IW-1:0] vCnt;

  always_ff @(posedge clk) begin
    if (rst || resDone) vCnt <= '0;
    else if (resValid)  vCnt <= vCnt + 1'b1;
  end

  a_r2_done_has_valid: assert property (@(posedge clk) disable iff (rst)
    resDone |-> resValid);

  a_r2_start_opens_row: assert property (@(posedge clk) disable iff (rst)
    (start && !resValid) |=> resValid);

  a_r2_row_contiguous: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resDone) |=> resValid);

  a_r2_row_length: assert property (@(posedge clk) disable iff (rst)
    resDone |-> (vCnt == LASTIDX));

  a_r7_no_restart_after_done: assert property (@(posedge clk) disable iff (rst)
    resDone |=> !resValid);
endmodule

bind bigRowMac bigRowMacChk #(.LIMBS(LIMBS)) uChk (
  .clk(clk), .rst(rst), .start(start), .resValid(resValid), .resDone(resDone)
);

// File: tb/sim_bigRowMac.sv
module sim_bigRowMac;
  localparam int LIMBS = 4;
  localparam int LW = 64;
  localparam int AW = LIMBS * LW;
  localparam int FW = LW * (LIMBS + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, start, accEn;
  logic [AW-1:0] aLimbs, cLimbs;
  logic [LW-1:0] bLimb, resLimb;
  logic          resValid, resDone;

  bigRowMac #(.LIMBS(LIMBS), .LW(LW)) u0 (
    .clk(clk), .rst(rst), .start(start), .accEn(accEn),
    .aLimbs(aLimbs), .bLimb(bLimb), .cLimbs(cLimbs),
    .resLimb(resLimb), .resValid(resValid), .resDone(resDone)
  );

  typedef struct {
    logic [LW-1:0] limb;
    logic          last;
    string         tag;
  } expItem_t;

  expItem_t sbq[$];
  int  nChk = 0;
  int  nBad = 0;
  bit  monOff = 1'b0;
  bit  ended = 1'b0;

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  function automatic logic [LW-1:0] rndLimb();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [AW-1:0] rndWide();
    logic [AW-1:0] v;
    for (int k = 0; k < LIMBS; k++) v[k*LW +: LW] = rndLimb();
    return v;
  endfunction

  // expected limbs from the full-width value A*B + C
  task automatic pushRow(input logic [AW-1:0] a, input logic [LW-1:0] b,
                         input logic [AW-1:0] c, input logic acc, input string tag);
    logic [FW-1:0] full;
    expItem_t it;
    full = FW'(a) * FW'(b) + (acc ? FW'(c) : FW'(0));
    for (int k = 0; k <= LIMBS; k++) begin
      it.limb = full[k*LW +: LW];
      it.last = (k == LIMBS);
      it.tag  = {tag, (k == 0) ? "/R3" : ((k == LIMBS) ? "/R5" : "/R4")};
      sbq.push_back(it);
    end
  endtask

  // driver: pushes the expectation, pulses start, optionally disturbs inputs
  task automatic runRow(input logic [AW-1:0] a, input logic [LW-1:0] b,
                        input logic [AW-1:0] c, input logic acc,
                        input string tag, input bit noise);
    pushRow(a, b, c, acc, tag);
    @(negedge clk);
    aLimbs = a; bLimb = b; cLimbs = c; accEn = acc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= LIMBS; i++) begin
      if (noise) begin
        aLimbs = rndWide(); bLimb = rndLimb(); cLimbs = rndWide();
        accEn = ~acc; start = 1'b1;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic checkBit(input logic got, input logic exp, input string what);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  // monitor: pops and compares as limbs appear
  always @(negedge clk) begin
    expItem_t e;
    if (!rst && !monOff && !ended) begin
      if (resValid) begin
        nChk++;
        if (sbq.size() == 0) begin
          nBad++;
          $display("FAIL R2 unexpected valid: got limb %h expected no output", resLimb);
        end else begin
          e = sbq.pop_front();
          if (resLimb !== e.limb || resDone !== e.last) begin
            nBad++;
            $display("FAIL %s: got limb %h done %b expected limb %h done %b",
                     e.tag, resLimb, resDone, e.limb, e.last);
          end
        end
      end else if (resDone) begin
        nChk++; nBad++;
        $display("FAIL R2 done without valid: got 1 expected 0");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL R2 watchdog expired: got hang expected completion");
    finishRun();
  end

  initial begin
    logic [AW-1:0] allA;
    logic [LW-1:0] allB;
    allA = '1; allB = '1;
    rst = 1'b1; start = 1'b0; accEn = 1'b0;
    aLimbs = '0; bLimb = '0; cLimbs = '0;
    repeat (3) @(negedge clk);
    checkBit(resValid, 1'b0, "R1 valid in reset");
    checkBit(resDone, 1'b0, "R1 done in reset");
    rst = 1'b0;

    runRow({64'd4, 64'd3, 64'd2, 64'd1}, 64'd3, {64'd40, 64'd30, 64'd20, 64'd10},
           1'b1, "R4", 1'b0);
    runRow(rndWide(), rndLimb(), rndWide(), 1'b0, "R6", 1'b0);
    runRow(allA, allB, allA, 1'b1, "R8", 1'b0);
    runRow(allA, allB, allA, 1'b0, "R8", 1'b0);
    runRow(rndWide(), 64'd0, rndWide(), 1'b1, "R3", 1'b0);
    runRow(allA, 64'd1, {192'd0, 64'd1}, 1'b1, "R4", 1'b0);
    runRow(rndWide(), rndLimb(), rndWide(), 1'b1, "R7", 1'b1);
    runRow(allA, allB, allA, 1'b1, "R9", 1'b1);
    for (int r = 0; r < 20; r++)
      runRow(rndWide(), rndLimb(), rndWide(), r[0], "R2", r[1]);

    // reset in the middle of a row
    monOff = 1'b1;
    @(negedge clk);
    aLimbs = allA; bLimb = allB; cLimbs = allA; accEn = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkBit(resValid, 1'b0, "R1 valid after mid-row reset");
    checkBit(resDone, 1'b0, "R1 done after mid-row reset");
    rst = 1'b0;
    monOff = 1'b0;
    runRow({64'd0, 64'd0, 64'd0, 64'd5}, 64'd7, {64'd0, 64'd0, 64'd0, 64'd1},
           1'b1, "R1", 1'b0);

    repeat (3) @(negedge clk);
    nChk++;
    if (sbq.size() != 0) begin
      nBad++;
      $display("FAIL R2 missing limbs: got %0d left expected 0", sbq.size());
    end
    finishRun();
  end
endmodule